// File: doc/BRIEF.md
# Compare-Mode Timer Waveform Output

This block is an up-counting timer that produces a pulse-width waveform on one output pin. The counter runs from a programmed reload value up to all-ones. On the overflow it loads the reload value again and the pin goes back to its starting level. When the count equals a programmed compare value, the pin switches to the opposite level. The timer can also be split into two independent half-width counters. In that case only the upper half drives the pin, and the lower half runs as a free timer whose only visible result is its own overflow flag.

A single-shot request loads the counter and emits exactly one reload-to-overflow period. After that period the counter stops, unless the run bit keeps it going. In full-width mode a gate input can hold back the start of a single shot. The starting level of the pin comes from a polarity bit. That bit is taken in only when the output enable goes from 0 to 1. While the output is disabled, the pin carries a plain software-written level.

All settings go through one write port with three addresses: control (0), reload (1) and compare (2). Control bits: 0 output enable, 1 polarity, 2 main run, 3 lower-half run, 4 split mode, 5 single shot (not stored), 6 gate enable, 7 idle pin level, 8 write-one-to-clear both overflow flags (not stored).

Top module: `cmp_wave_timer`

## Requirements
- R1: While control bit 0 (output enable) is 0, `pin_out` equals control bit 7. After reset this value is 0, and both flags are 0.
- R2: A control write that changes output enable from 0 to 1 sets the pin level to the written bit 1 (1 = high) right after that write's clock edge. This level becomes the starting level.
- R3: A change of bit 1 while output enable stays 1 does not alter the starting level or the waveform.
- R4: In full-width mode a running counter increments once per clock. When it is at all-ones it loads the reload value and the pin returns to the starting level. When the count equals the compare value (and no overflow occurs), the pin takes the opposite level. One period lasts 2^16 − reload cycles, of which 0xFFFF − compare cycles are at the opposite level.
- R5: Each overflow of the pin counter sets `ovf_flag[1]`. Each lower-half overflow in split mode sets `ovf_flag[0]`. A flag stays set until a control write with bit 8 = 1.
- R6: A control write with bit 5 = 1 loads the counter with the reload value at that edge and produces exactly one period on the pin. If run (bit 2) is 0, the counter then holds, the pin stays at the starting level and no further overflow occurs.
- R7: If single shot and run are both set, counting goes on after the single period with unchanged period and duty.
- R8: In full-width mode, with gate enable (bit 6) = 1 and `gate_in` = 1 at the single-shot write, the counter holds at the reload value and the pin stays at the starting level. The shot starts once `gate_in` is 0.
- R9: In split mode (bit 4 = 1) the pin follows the upper half, using reload[15:8] and compare[15:8]. Its period is 256 − reload[15:8] cycles, with 0xFF − compare[15:8] cycles at the opposite level.
- R10: In split mode bit 2 runs only the upper half and bit 3 runs only the lower half. A stopped half holds its count: the pin stays constant, or no lower overflow occurs.
- R11: In full-width mode bit 3 has no effect.
- R12: In split mode the gate never delays a single shot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 reload, 2 compare |
| wr_data | input | 16 | Write data |
| gate_in | input | 1 | Gate; level 1 defers a full-width single shot when enabled |
| pin_out | output | 1 | Waveform or idle level |
| ovf_flag | output | 2 | Sticky overflow flags: [1] pin counter, [0] lower half |

## Verification
Duty counts are taken over whole periods that start at a single-shot load. A compare match or overflow placed one cycle off therefore changes the count of high cycles. A polarity bit latched on every write would flip the duty count in the test that rewrites polarity mid-run. A single shot that does not stop, or a lower run bit that leaks into full-width mode, would set the flag again during a long watch after it was cleared. A gate that is ignored in full-width mode, or obeyed in split mode, would show up as pin activity during the held window, or as a missing period.

// File: rtl/cw_pkg.sv
package cw_pkg;

    localparam int CTL_W  = 9;
    localparam logic [1:0] A_CTL = 2'd0;
    localparam logic [1:0] A_RLD = 2'd1;
    localparam logic [1:0] A_CMP = 2'd2;

    // control word as written (bit 8 down to bit 0)
    typedef struct packed {
        logic clr;
        logic idle_lvl;
        logic gate_en;
        logic shot;
        logic split;
        logic run_lo;
        logic run_hi;
        logic pol;
        logic oe;
    } ctl_word_t;

    // stored part of the control word
    typedef struct packed {
        logic idle_lvl;
        logic gate_en;
        logic split;
        logic run_lo;
        logic run_hi;
        logic oe;
    } cfg_t;

    typedef enum logic [1:0] {
        SHOT_IDLE = 2'd0,
        SHOT_WAIT = 2'd1,
        SHOT_RUN  = 2'd2
    } shot_e;

    function automatic cfg_t keep_cfg(input ctl_word_t w);
        cfg_t c;
        c.idle_lvl = w.idle_lvl;
        c.gate_en  = w.gate_en;
        c.split    = w.split;
        c.run_lo   = w.run_lo;
        c.run_hi   = w.run_hi;
        c.oe       = w.oe;
        return c;
    endfunction

endpackage

// File: rtl/cw_regs.sv
module cw_regs
    import cw_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          ovf_pin,
    input  logic          ovf_lo,
    output cfg_t          cfg_q,
    output ctl_word_t     wctl,
    output logic          ctl_wr,
    output logic          arm,
    output logic          start_lvl,
    output logic [DW-1:0] rld_q,
    output logic [DW-1:0] cmp_q,
    output logic [1:0]    ovf_flag
);

    logic clr;

    assign wctl   = ctl_word_t'(wr_data[CTL_W-1:0]);
    assign ctl_wr = wr_en && (wr_addr == A_CTL);
    assign arm    = ctl_wr && !cfg_q.oe && wctl.oe;
    assign clr    = ctl_wr && wctl.clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= '0;
            start_lvl <= 1'b0;
            rld_q     <= '0;
            cmp_q     <= '0;
            ovf_flag  <= '0;
        end else begin
            if (ctl_wr) cfg_q <= keep_cfg(wctl);
            if (arm) start_lvl <= wctl.pol;
            if (wr_en && wr_addr == A_RLD) rld_q <= wr_data;
            if (wr_en && wr_addr == A_CMP) cmp_q <= wr_data;
            ovf_flag <= (ovf_flag & {2{!clr}}) | {ovf_pin, ovf_lo};
        end
    end

endmodule

// File: rtl/cw_counter.sv
module cw_counter #(
    parameter int HW = 8,
    localparam int DW = 2 * HW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          split,
    input  logic          en_hi,
    input  logic          en_lo,
    input  logic          load_pin,
    input  logic [DW-1:0] rld,
    input  logic [DW-1:0] cmp,
    output logic [DW-1:0] cnt,
    output logic          ovf_pin,
    output logic          ovf_lo,
    output logic          match_pin
);

    logic full_max, hi_max, lo_max;

    assign full_max  = &cnt;
    assign hi_max    = &cnt[DW-1:HW];
    assign lo_max    = &cnt[HW-1:0];
    assign ovf_pin   = en_hi && !load_pin && (split ? hi_max : full_max);
    assign ovf_lo    = split && en_lo && lo_max;
    assign match_pin = split ? (cnt[DW-1:HW] == cmp[DW-1:HW]) : (cnt == cmp);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (!split) begin
            if (load_pin)    cnt <= rld;
            else if (en_hi)  cnt <= full_max ? rld : cnt + 1'b1;
        end else begin
            if (load_pin)    cnt[DW-1:HW] <= rld[DW-1:HW];
            else if (en_hi)  cnt[DW-1:HW] <= hi_max ? rld[DW-1:HW] : cnt[DW-1:HW] + 1'b1;
            if (en_lo)       cnt[HW-1:0]  <= lo_max ? rld[HW-1:0] : cnt[HW-1:0] + 1'b1;
        end
    end

endmodule

// File: rtl/cw_wave.sv
module cw_wave
    import cw_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cfg_t      cfg_q,
    input  ctl_word_t wctl,
    input  logic      ctl_wr,
    input  logic      arm,
    input  logic      start_lvl,
    input  logic      gate_in,
    input  logic      ovf_pin,
    input  logic      match_pin,
    output logic      en_hi,
    output logic      load_pin,
    output logic      wave,
    output shot_e     shot_q
);

    logic shot_wr, gated_new, gated_now, flip;

    assign shot_wr   = ctl_wr && wctl.shot;
    assign gated_new = wctl.gate_en && gate_in && !wctl.split;
    assign gated_now = cfg_q.gate_en && gate_in && !cfg_q.split;
    assign load_pin  = shot_wr;
    assign en_hi     = (shot_q == SHOT_RUN) || (cfg_q.run_hi && shot_q != SHOT_WAIT);
    assign flip      = en_hi && !load_pin && match_pin && !ovf_pin;

    always_ff @(posedge clk) begin
        if (rst) begin
            shot_q <= SHOT_IDLE;
        end else if (shot_wr) begin
            shot_q <= gated_new ? SHOT_WAIT : SHOT_RUN;
        end else begin
            case (shot_q)
                SHOT_WAIT: if (!gated_now) shot_q <= SHOT_RUN;
                SHOT_RUN:  if (ovf_pin)    shot_q <= SHOT_IDLE;
                default:   shot_q <= SHOT_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          wave <= 1'b0;
        else if (arm)     wave <= wctl.pol;
        else if (shot_wr) wave <= start_lvl;
        else if (ovf_pin) wave <= start_lvl;
        else if (flip)    wave <= !start_lvl;
    end

endmodule

// File: rtl/cmp_wave_timer.sv
module cmp_wave_timer
    import cw_pkg::*;
#(
    parameter int HW = 8,
    localparam int DW = 2 * HW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          gate_in,
    output logic          pin_out,
    output logic [1:0]    ovf_flag
);

    cfg_t          cfg_q;
    ctl_word_t     wctl;
    logic          ctl_wr, arm, start_lvl;
    logic [DW-1:0] rld_q, cmp_q, cnt;
    logic          ovf_pin, ovf_lo, match_pin;
    logic          en_hi, en_lo, load_pin, wave;
    shot_e         shot_q;

    assign en_lo = cfg_q.split && cfg_q.run_lo;

    cw_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ovf_pin(ovf_pin), .ovf_lo(ovf_lo), .cfg_q(cfg_q), .wctl(wctl),
        .ctl_wr(ctl_wr), .arm(arm), .start_lvl(start_lvl), .rld_q(rld_q),
        .cmp_q(cmp_q), .ovf_flag(ovf_flag)
    );

    cw_counter #(.HW(HW)) u_cnt (
        .clk(clk), .rst(rst), .split(cfg_q.split), .en_hi(en_hi), .en_lo(en_lo),
        .load_pin(load_pin), .rld(rld_q), .cmp(cmp_q), .cnt(cnt),
        .ovf_pin(ovf_pin), .ovf_lo(ovf_lo), .match_pin(match_pin)
    );

    cw_wave u_wave (
        .clk(clk), .rst(rst), .cfg_q(cfg_q), .wctl(wctl), .ctl_wr(ctl_wr),
        .arm(arm), .start_lvl(start_lvl), .gate_in(gate_in), .ovf_pin(ovf_pin),
        .match_pin(match_pin), .en_hi(en_hi), .load_pin(load_pin), .wave(wave),
        .shot_q(shot_q)
    );

    assign pin_out = cfg_q.oe ? wave : cfg_q.idle_lvl;

endmodule

// File: rtl/cw_checker.sv
module cw_checker #(
    parameter int HW = 8,
    localparam int DW = 2 * HW
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic [1:0]    wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          oe,
    input logic          start_lvl,
    input logic          shot_wait,
    input logic [DW-1:0] cnt,
    input logic [DW-1:0] rld,
    input logic          ovf_pin,
    input logic [1:0]    ovf_flag,
    input logic          split,
    input logic          run_lo
);

    logic ctl_w;
    assign ctl_w = wr_en && wr_addr == 2'd0;

    p_ovf_sets_flag_r5: assert property (@(posedge clk) disable iff (rst)
        ovf_pin |=> ovf_flag[1]);

    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag[1] && !(ctl_w && wr_data[8])) |=> ovf_flag[1]);

    p_pol_held_r3: assert property (@(posedge clk) disable iff (rst)
        oe |=> (!oe || $stable(start_lvl)));

    p_shot_loads_r6: assert property (@(posedge clk) disable iff (rst)
        (ctl_w && wr_data[5] && !wr_data[4]) |=> cnt == $past(rld));

    p_wait_holds_r8: assert property (@(posedge clk) disable iff (rst)
        (shot_wait && !wr_en) |=> $stable(cnt));

    p_lo_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (split && !run_lo) |=> $stable(cnt[HW-1:0]));

endmodule

bind cmp_wave_timer cw_checker #(.HW(HW)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .oe(cfg_q.oe), .start_lvl(start_lvl), .shot_wait(shot_q == cw_pkg::SHOT_WAIT),
    .cnt(cnt), .rld(rld_q), .ovf_pin(ovf_pin), .ovf_flag(ovf_flag),
    .split(cfg_q.split), .run_lo(cfg_q.run_lo)
);

// File: tb/tb_cmp_wave_timer.sv
`timescale 1ns/1ps
module tb_cmp_wave_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        gate_in = 1'b0;
    logic        pin_out;
    logic [1:0]  ovf_flag;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cmp_wave_timer dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .gate_in(gate_in), .pin_out(pin_out), .ovf_flag(ovf_flag)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // control word: oe pol run_hi run_lo split shot gate idle clr
    function automatic logic [15:0] cw(input bit oe, input bit pol, input bit rh,
        input bit rl, input bit sp, input bit sh, input bit ge, input bit il, input bit cl);
        return {7'd0, cl, il, ge, sh, sp, rl, rh, pol, oe};
    endfunction

    task automatic count_hi(input int n, output int h);
        h = 0;
        repeat (n) begin
            @(negedge clk);
            if (pin_out) h++;
        end
    endtask

    task automatic count_toggles(input int n, output int t);
        logic last;
        t = 0;
        last = pin_out;
        repeat (n) begin
            @(negedge clk);
            if (pin_out != last) t++;
            last = pin_out;
        end
    endtask

    task automatic t_reset();
        check("R1 reset pin", pin_out, 0);
        check("R5 reset flags", ovf_flag, 0);
    endtask

    task automatic t_idle_level();
        wr(2'd0, cw(0,0,0,0,0,0,0,1,0));
        check("R1 idle level high", pin_out, 1);
        wr(2'd0, cw(0,1,0,0,0,0,0,0,0));
        check("R1 idle level low", pin_out, 0);
    endtask

    task automatic t_shot16();
        int h;
        wr(2'd1, 16'hFFF0);
        wr(2'd2, 16'hFFF8);
        wr(2'd0, cw(0,0,0,0,0,0,0,0,1));
        wr(2'd0, cw(1,0,0,0,0,1,0,0,0));
        check("R2 start level low", pin_out, 0);
        count_hi(40, h);
        check("R6 single period high cycles", h, 7);
        check("R5 flag after shot", ovf_flag[1], 1);
        check("R6 pin rests at start", pin_out, 0);
    endtask

    task automatic t_run16_and_pol();
        int h;
        wr(2'd0, cw(0,0,0,0,0,0,0,0,1));
        wr(2'd0, cw(1,0,1,0,0,1,0,0,0));
        count_hi(160, h);
        check("R4 R7 duty over 10 periods", h, 70);
        wr(2'd0, cw(1,1,1,0,0,0,0,0,0));
        count_hi(160, h);
        check("R3 polarity change ignored", h, 70);
        wr(2'd0, cw(0,1,0,0,0,0,0,0,0));
        wr(2'd0, cw(1,1,0,0,0,0,0,0,0));
        check("R2 start level high", pin_out, 1);
        wr(2'd0, cw(1,1,1,0,0,1,0,0,0));
        count_hi(160, h);
        check("R4 inverted duty", h, 90);
    endtask

    task automatic t_flag_clear();
        int h;
        wr(2'd0, cw(0,0,0,0,0,0,0,0,1));
        check("R5 flag cleared", ovf_flag, 0);
        count_hi(40, h);
        check("R5 flag stays clear when stopped", ovf_flag, 0);
    endtask

    task automatic t_lo_in_full();
        int h;
        wr(2'd0, cw(1,0,0,1,0,1,0,0,0));
        count_hi(40, h);
        check("R11 shot with lower run only", h, 7);
        wr(2'd0, cw(1,0,0,1,0,0,0,0,1));
        count_hi(300, h);
        check("R11 R6 counter held after shot", h, 0);
        check("R11 no overflow after shot", ovf_flag, 0);
    endtask

    task automatic t_gate16();
        int h;
        wr(2'd0, cw(0,0,0,0,0,0,0,0,1));
        gate_in = 1'b1;
        wr(2'd0, cw(1,0,0,0,0,1,1,0,0));
        count_hi(30, h);
        check("R8 gated shot held pin", h, 0);
        check("R8 gated shot no overflow", ovf_flag, 0);
        gate_in = 1'b0;
        count_hi(40, h);
        check("R8 shot after gate release", h, 7);
        check("R8 overflow after release", ovf_flag[1], 1);
    endtask

    task automatic t_split();
        int h;
        int t;
        wr(2'd1, 16'hF0F0);
        wr(2'd2, 16'hF8F4);
        wr(2'd0, cw(0,0,0,0,0,0,0,0,1));
        gate_in = 1'b1;
        wr(2'd0, cw(1,0,1,0,1,1,1,0,0));
        count_hi(160, h);
        check("R9 R12 upper half duty, gate ignored", h, 70);
        count_hi(300, h);
        check("R10 lower half stopped", ovf_flag[0], 0);
        gate_in = 1'b0;
        wr(2'd0, cw(1,0,1,1,1,0,0,0,0));
        count_hi(160, h);
        check("R10 pin unaffected by lower half", h, 70);
        count_hi(140, h);
        check("R10 R5 lower half overflow flag", ovf_flag[0], 1);
        wr(2'd0, cw(1,0,0,1,1,0,0,0,0));
        count_toggles(60, t);
        check("R10 upper half held", t, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_idle_level();
        t_shot16();
        t_run16_and_pol();
        t_flag_clear();
        t_lo_in_full();
        t_gate16();
        t_split();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule